// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block pulls the vertical sync interval out of a composite sync signal that carries both line and frame pulses. A digital integrator, an up/down counter stepped by a slow sample tick, tells the two apart by how long each pulse lasts. Line pulses are short, so the count climbs only a little and then drains away before the next one. A frame pulse lasts long enough to push the count past a programmable threshold.

Once the vertical interval is declared, the counter is cleared and reused as a timer. It measures how long the input stays continuously inactive. Any active sample restarts that timer, so noise spikes and serration pulses inside the vertical interval cannot end it early. Vertical sync is declared over only when the inactive time reaches the same threshold. The block then clears the counter and goes back to integrating.

The composite input is asynchronous and of either polarity. A select pin turns it into active-high form before a synchronizer brings it into the clock domain. All pins are plain level signals: there is no data stream and no back-pressure. The threshold is read on every tick, so a new value applies from the next tick.

Top module: `csync_vsep`

## Requirements
- R1: While `rst_n` is low and after it is released, `vsync_out` is 0, the count is 0 and the block is in the integrating (not detected) phase.
- R2: The internal sync level is `csync_in XOR csync_invert`: with `csync_invert`=1, a low input counts as active.
- R3: A change on `csync_in` is seen by the counter only after two clock edges of synchronization. The first tick that can count it is at the third rising edge after the change.
- R4: In the integrating phase, each tick with sync active raises the count by one, saturating at 255. Each tick with sync inactive lowers it by one, stopping at 0. The count never wraps.
- R5: In the integrating phase, on a tick where the raised count would be greater than `thresh`, `vsync_out` goes to 1 at that edge and the count is cleared to 0.
- R6: Starting from a count of 0, a pulse lasting at most `thresh` active ticks never raises `vsync_out`.
- R7: In the detected phase, each tick with sync inactive raises the count, and on the tick where it reaches `thresh` `vsync_out` returns to 0. The count is then cleared and the block goes back to integrating.
- R8: In the detected phase, a tick with sync active clears the inactive-time count. Gaps shorter than `thresh` ticks, separated by active pulses, therefore keep `vsync_out` at 1.
- R9: On clock edges with `tick_en` low, neither the count, the phase nor `vsync_out` changes.
- R10: With `thresh`=255, a continuously active input never raises `vsync_out`, because the saturated count cannot exceed 255.
- R11: A new `thresh` value applies from the next tick. With the count held at 255, lowering `thresh` below 255 raises `vsync_out` on the very next tick with sync active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Sample tick, one clock wide, nominally every 200 ns |
| csync_in | input | 1 | Raw composite sync, asynchronous |
| csync_invert | input | 1 | 1 when the composite sync is active-low |
| thresh | input | 8 | Detection and loss threshold in ticks |
| vsync_out | output | 1 | Separated vertical sync, registered, active high |

## Verification
The bench builds the block with its default 8-bit counter and two-stage synchronizer. At this width, saturation at 255 takes only a few hundred ticks, so the bench can hold the counter against its ceiling with the threshold at 255 and then lower the threshold. With a tick on most clock cycles, small random thresholds make detection, serration-filtered holding and loss all happen many times within a short run, including ticks taken while the input is changing.

// File: rtl/csync_vsep_pkg.sv
package csync_vsep_pkg;

  // Integrator phase: accumulate pulse width, or time the inactive gap.
  typedef enum logic {
    PH_INTEG = 1'b0,
    PH_GAP   = 1'b1
  } vsep_phase_e;

endpackage

// File: rtl/csync_vsep_sync.sv
module csync_vsep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= 1'b0;
        end else if (i == 0) begin
          chain_q[i] <= d_async;
        end else begin
          chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/csync_vsep_integ.sv
module csync_vsep_integ
  import csync_vsep_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             act,
  input  logic [CNT_W-1:0] thresh,
  output logic             vsync_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  vsep_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_up, cnt_dn;
  logic             vsync_d;

  // Saturating neighbours of the current count.
  always_comb begin
    cnt_up = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    cnt_dn = (cnt_q == '0)      ? cnt_q : cnt_q - CNT_ONE;
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    vsync_d = vsync_q;
    if (tick_en) begin
      unique case (phase_q)
        PH_INTEG: begin
          if (!act) begin
            cnt_d = cnt_dn;
          end else if (cnt_up > thresh) begin
            phase_d = PH_GAP;
            cnt_d   = '0;
            vsync_d = 1'b1;
          end else begin
            cnt_d = cnt_up;
          end
        end
        PH_GAP: begin
          if (act) begin
            cnt_d = '0;
          end else if (cnt_up >= thresh) begin
            phase_d = PH_INTEG;
            cnt_d   = '0;
            vsync_d = 1'b0;
          end else begin
            cnt_d = cnt_up;
          end
        end
        default: begin
          phase_d = PH_INTEG;
          cnt_d   = '0;
          vsync_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INTEG;
      cnt_q   <= '0;
      vsync_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      vsync_q <= vsync_d;
    end
  end

endmodule

// File: rtl/csync_vsep.sv
module csync_vsep #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             csync_in,
  input  logic             csync_invert,
  input  logic [CNT_W-1:0] thresh,
  output logic             vsync_out
);

  logic csync_norm;
  logic act_s;

  // Normalize to active-high before crossing into the clock domain.
  assign csync_norm = csync_in ^ csync_invert;

  csync_vsep_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (csync_norm),
    .q_sync  (act_s)
  );

  csync_vsep_integ #(
    .CNT_W (CNT_W)
  ) u_integ (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .act     (act_s),
    .thresh  (thresh),
    .vsync_q (vsync_out)
  );

endmodule

// File: rtl/csync_vsep_chk.sv
module csync_vsep_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             act,
  input logic             phase,
  input logic [CNT_W-1:0] cnt,
  input logic             vsync
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1: first cycle out of reset shows the idle state.
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!vsync && cnt == '0 && !phase));

  // R9: no tick, no movement.
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cnt) && $stable(vsync) && $stable(phase)));

  // R4: saturation at the top while integrating, unless detection fires.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !phase && act && cnt == CMAX) |=> (cnt == CMAX || vsync));

  // R4: floor at zero while integrating.
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !phase && !act && cnt == '0) |=> cnt == '0);

  // R5: a rise happens only on a tick with sync active, with the count cleared.
  assert_rise_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> ($past(tick_en) && $past(act) && cnt == '0 && phase));

  // R7: a fall happens only on a tick with sync inactive, with the count cleared.
  assert_fall_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |-> ($past(tick_en) && !$past(act) && cnt == '0 && !phase));

  // R8: an active tick in the gap phase restarts the gap timer.
  assert_gap_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && phase && act) |=> (cnt == '0 && vsync));

endmodule

bind csync_vsep_integ csync_vsep_chk #(
  .CNT_W (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .act     (act),
  .phase   (phase_q),
  .cnt     (cnt_q),
  .vsync   (vsync_q)
);

// File: tb/csync_vsep_test.sv
module csync_vsep_test;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          csync_in = 1'b0;
  logic          csync_invert = 1'b0;
  logic [CW-1:0] thresh = 8'd10;
  logic          vsync_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference model state.
  bit m_s1, m_s2, m_lock;
  int m_cnt;

  always #2 clk = ~clk;

  csync_vsep #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .csync_in(csync_in),
    .csync_invert(csync_invert), .thresh(thresh), .vsync_out(vsync_out)
  );

  task automatic check(input bit got, input bit exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: vsync_out=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // One step of the expected behaviour, applied for the edge just taken.
  function automatic void model_edge(bit rst, bit tick, bit raw, bit inv, int thr);
    int n;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_lock = 0; m_cnt = 0;
      return;
    end
    if (tick) begin
      n = (m_cnt == 255) ? 255 : m_cnt + 1;
      if (!m_lock) begin
        if (!m_s2)          m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
        else if (n > thr) begin m_lock = 1; m_cnt = 0; end
        else                m_cnt = n;
      end else begin
        if (m_s2)            m_cnt = 0;
        else if (n >= thr) begin m_lock = 0; m_cnt = 0; end
        else                 m_cnt = n;
      end
    end
    m_s2 = m_s1;
    m_s1 = raw ^ inv;
  endfunction

  // Drive at the falling edge, take one rising edge, compare just after it.
  task automatic cyc(input bit raw, input bit tick);
    @(negedge clk);
    csync_in = raw;
    tick_en  = tick;
    @(posedge clk);
    #1;
    model_edge(!rst_n, tick, raw, csync_invert, int'(thresh));
    check(vsync_out, m_lock, "R4/R5/R7 model");
  endtask

  task automatic run(input int n, input bit raw, input bit tick);
    for (int i = 0; i < n; i++) cyc(raw, tick);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1: reset state.
    run(4, 1'b1, 1'b1);
    check(vsync_out, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    run(3, 1'b0, 1'b1);
    check(vsync_out, 1'b0, "R1 after reset");

    // R6: line-width pulses of 5 ticks with threshold 10.
    thresh = 8'd10;
    for (int p = 0; p < 6; p++) begin
      run(5, 1'b1, 1'b1);
      run(15, 1'b0, 1'b1);
    end
    check(vsync_out, 1'b0, "R6 short pulses rejected");
    // Exactly threshold ticks, from zero, still rejected.
    run(10, 1'b1, 1'b1);
    run(2, 1'b0, 1'b1);
    check(vsync_out, 1'b0, "R6 pulse of thresh ticks");
    run(20, 1'b0, 1'b1);

    // R3 and R5: timing of detection on a long pulse.
    run(12, 1'b1, 1'b1);
    check(vsync_out, 1'b0, "R3 two-edge delay, not yet");
    run(1, 1'b1, 1'b1);
    check(vsync_out, 1'b1, "R5 detected on eleventh tick");

    // R8: serrations during the vertical interval.
    for (int p = 0; p < 5; p++) begin
      run(8, 1'b0, 1'b1);
      run(1, 1'b1, 1'b1);
    end
    check(vsync_out, 1'b1, "R8 serrations keep vsync");
    // R7: gap timing; the last active sample is still in the synchronizer.
    run(11, 1'b0, 1'b1);
    check(vsync_out, 1'b1, "R7 gap one short");
    run(1, 1'b0, 1'b1);
    check(vsync_out, 1'b0, "R7 loss at threshold");

    // R9: a long active input without ticks changes nothing.
    run(300, 1'b1, 1'b0);
    check(vsync_out, 1'b0, "R9 no tick holds state");
    run(20, 1'b0, 1'b1);

    // R10: threshold 255 never detects, counter pinned at 255.
    thresh = 8'd255;
    run(600, 1'b1, 1'b1);
    check(vsync_out, 1'b0, "R10 thresh 255 never detects");
    // R11: lower it; next tick detects.
    run(5, 1'b1, 1'b0);
    thresh = 8'd20;
    cyc(1'b1, 1'b1);
    check(vsync_out, 1'b1, "R11 new thresh on next tick");
    run(40, 1'b0, 1'b1);
    check(vsync_out, 1'b0, "R7 loss after R11");

    // R2: active-low input.
    csync_invert = 1'b1;
    run(10, 1'b1, 1'b1);
    check(vsync_out, 1'b0, "R2 high is idle when inverted");
    run(30, 1'b0, 1'b1);
    check(vsync_out, 1'b1, "R2 low is active when inverted");
    run(30, 1'b1, 1'b1);
    check(vsync_out, 1'b0, "R2 inverted loss");
    csync_invert = 1'b0;
    run(5, 1'b0, 1'b1);

    // Random segments against the model.
    for (int seg = 0; seg < 400; seg++) begin
      int len;
      bit lvl;
      if (seg % 40 == 0) thresh = CW'(3 + $urandom_range(0, 37));
      len = $urandom_range(1, 60);
      lvl = ($urandom_range(0, 99) < 45);
      for (int i = 0; i < len; i++) cyc(lvl, $urandom_range(0, 9) < 7);
    end

    finish_up();
  end

endmodule